// File: doc/BRIEF.md
# SPI Controller Interrupt Register Set

This block holds the interrupt bookkeeping registers of an SPI controller. It sits on a simple 32-bit register bus with one address, a write strobe and a combinational read path. Seven interrupt source bits share one layout across the status, enable, disable and mask registers. Some sources are pulses that latch into the status register and stay until software writes a 1 to clear them. Others mirror a live FIFO level and follow their input directly. A level interrupt output is raised whenever any status bit is set while its mask bit is also set.

The mask cannot be written directly. Software turns sources on by writing 1s to a write-only enable register and turns them off by writing 1s to a write-only disable register. The block also keeps a one-bit controller enable and a TX FIFO watermark threshold. It drives both outputs to the rest of the controller. FIFO storage and the shift engine are outside this block.

Top module: `spi_irq_regfile`

## Requirements
- R1: After reset the latched status bits, the mask and the controller enable read 0, the TX watermark reads 1, and `irq_o` is low.
- R2: Latched sources (bits 0, 1 mode fault, 2 TX over watermark, 5, 6) set their status bit at the clock edge where `evt_i` for that bit is 1. The bit stays set with no further event until cleared. Status is read at offset 0x04.
- R3: A bus write to offset 0x04 clears exactly those latched status bits that are 1 in the written data. Bits written 0 are unchanged.
- R4: Status bit 3 (TX FIFO full) and bit 4 (RX FIFO not empty) read as the current level of `evt_i[3]` and `evt_i[4]` in the same cycle. Writing 1 to them at 0x04 has no effect.
- R5: When a latched event and a clearing write hit the same status bit on the same edge, the bit ends up set.
- R6: Writing to offset 0x08 sets the mask bits where the data has a 1. Bits written 0 and data bits above bit 6 have no effect.
- R7: Writing to offset 0x0C clears the mask bits where the data has a 1. Bits written 0 have no effect.
- R8: The mask reads at offset 0x10. Bus writes to 0x10 leave it unchanged.
- R9: Reads of the write-only offsets 0x08 and 0x0C, and of unmapped offsets, return 0.
- R10: `irq_o` is high in the same cycle as any bit is set in both the status and the mask, and low otherwise.
- R11: Offset 0x14 holds the controller enable in bit 0. It is driven on `ctrl_en_o`, and its other bits read 0.
- R12: Offset 0x28 holds the 7-bit TX watermark, driven on `tx_wmark_o`. Data bits above bit 6 are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | 6 | Byte offset for read and write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| evt_i | input | 7 | Interrupt sources: pulses for latched bits, levels for bits 3 and 4 |
| irq_o | output | 1 | Level interrupt request |
| ctrl_en_o | output | 1 | Controller enable |
| tx_wmark_o | output | 7 | TX FIFO watermark threshold |

## Verification
A write or a latched event takes effect on the clock edge that samples it. Its result is therefore due at the first falling edge after that rising edge. Live FIFO bits, the read path and `irq_o` are combinational, so they are due in the cycle their inputs change. The bench drives every input just after a rising edge. It advances a behavioural model on the rising edge and compares the read data, `irq_o`, `ctrl_en_o` and `tx_wmark_o` against that model on each falling edge. The directed checks sample at the same falling edge.

// File: rtl/spi_irq_pkg.sv
package spi_irq_pkg;

   // Byte offsets of the interrupt register set
   localparam logic [7:0] OFS_STATUS = 8'h04;
   localparam logic [7:0] OFS_MSET   = 8'h08;
   localparam logic [7:0] OFS_MCLR   = 8'h0C;
   localparam logic [7:0] OFS_MASK   = 8'h10;
   localparam logic [7:0] OFS_CTRL   = 8'h14;
   localparam logic [7:0] OFS_WMARK  = 8'h28;

   typedef enum logic [2:0] {
      SEL_NONE,
      SEL_STATUS,
      SEL_MSET,
      SEL_MCLR,
      SEL_MASK,
      SEL_CTRL,
      SEL_WMARK
   } reg_sel_e;

endpackage

// File: rtl/spi_irq_decode.sv
module spi_irq_decode
   import spi_irq_pkg::*;
#(
   parameter int ADDR_W = 6
) (
   input  logic [ADDR_W-1:0] addr,
   output reg_sel_e          sel
);

   always_comb begin
      if (addr == ADDR_W'(OFS_STATUS))      sel = SEL_STATUS;
      else if (addr == ADDR_W'(OFS_MSET))   sel = SEL_MSET;
      else if (addr == ADDR_W'(OFS_MCLR))   sel = SEL_MCLR;
      else if (addr == ADDR_W'(OFS_MASK))   sel = SEL_MASK;
      else if (addr == ADDR_W'(OFS_CTRL))   sel = SEL_CTRL;
      else if (addr == ADDR_W'(OFS_WMARK))  sel = SEL_WMARK;
      else                                  sel = SEL_NONE;
   end

endmodule

// File: rtl/spi_irq_status.sv
module spi_irq_status #(
   parameter int                 NUM_SRC   = 7,
   parameter logic [NUM_SRC-1:0] LIVE_MASK = '0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] evt_i,
   input  logic               clr_en,
   input  logic [NUM_SRC-1:0] clr_bits,
   output logic [NUM_SRC-1:0] status_o
);

   for (genvar b = 0; b < NUM_SRC; b++) begin : g_bit
      if (LIVE_MASK[b]) begin : g_live
         // Mirrors a FIFO level; software clears do not reach it
         logic unused_clr;
         assign unused_clr  = clr_bits[b];
         assign status_o[b] = evt_i[b];
      end else begin : g_latch
         logic bit_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               bit_q <= 1'b0;
            else
               // clear first, then OR the event so a same-edge set survives
               bit_q <= (bit_q & ~(clr_en & clr_bits[b])) | evt_i[b];
         end
         assign status_o[b] = bit_q;
      end
   end

endmodule

// File: rtl/spi_irq_mask.sv
module spi_irq_mask #(
   parameter int NUM_SRC = 7
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               set_en,
   input  logic               clr_en,
   input  logic [NUM_SRC-1:0] bits,
   output logic [NUM_SRC-1:0] mask_o
);

   logic [NUM_SRC-1:0] mask_q;
   logic [NUM_SRC-1:0] set_v;
   logic [NUM_SRC-1:0] clr_v;

   assign set_v = set_en ? bits : '0;
   assign clr_v = clr_en ? bits : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         mask_q <= '0;
      else
         mask_q <= (mask_q | set_v) & ~clr_v;
   end

   assign mask_o = mask_q;

endmodule

// File: rtl/spi_irq_regfile.sv
module spi_irq_regfile
   import spi_irq_pkg::*;
#(
   parameter int                ADDR_W    = 6,
   parameter int                DATA_W    = 32,
   parameter int                NUM_SRC   = 7,
   parameter logic [DATA_W-1:0] LIVE_MASK = 32'h0000_0018,
   parameter int                WM_W      = 7,
   parameter int                WM_RESET  = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic [NUM_SRC-1:0] evt_i,
   output logic              irq_o,
   output logic              ctrl_en_o,
   output logic [WM_W-1:0]   tx_wmark_o
);

   localparam logic [NUM_SRC-1:0] SRC_LIVE = LIVE_MASK[NUM_SRC-1:0];

   // Elaboration-time parameter checks
   if (NUM_SRC < 1 || NUM_SRC > DATA_W) begin : g_bad_src
      $error("spi_irq_regfile: NUM_SRC out of range");
   end
   if (WM_W < 1 || WM_W > DATA_W) begin : g_bad_wm
      $error("spi_irq_regfile: WM_W out of range");
   end
   if (WM_RESET < 0 || WM_RESET >= (1 << WM_W)) begin : g_bad_wmr
      $error("spi_irq_regfile: WM_RESET does not fit WM_W");
   end
   if (ADDR_W < 6) begin : g_bad_addr
      $error("spi_irq_regfile: ADDR_W too small for the register offsets");
   end

   reg_sel_e           sel;
   logic               wr_status, wr_mset, wr_mclr, wr_ctrl, wr_wmark;
   logic [NUM_SRC-1:0] status_w;
   logic [NUM_SRC-1:0] mask_w;
   logic [NUM_SRC-1:0] src_wdata;
   logic               ctrl_q;
   logic [WM_W-1:0]    wm_q;
   logic [DATA_W-1:0]  rdata_c;
   logic               unused_bus;

   assign src_wdata  = bus_wdata[NUM_SRC-1:0];
   assign unused_bus = ^bus_wdata;

   spi_irq_decode #(.ADDR_W(ADDR_W)) u_decode (
      .addr (bus_addr),
      .sel  (sel)
   );

   assign wr_status = bus_wr && (sel == SEL_STATUS);
   assign wr_mset   = bus_wr && (sel == SEL_MSET);
   assign wr_mclr   = bus_wr && (sel == SEL_MCLR);
   assign wr_ctrl   = bus_wr && (sel == SEL_CTRL);
   assign wr_wmark  = bus_wr && (sel == SEL_WMARK);

   spi_irq_status #(
      .NUM_SRC   (NUM_SRC),
      .LIVE_MASK (SRC_LIVE)
   ) u_status (
      .clk      (clk),
      .rst_n    (rst_n),
      .evt_i    (evt_i),
      .clr_en   (wr_status),
      .clr_bits (src_wdata),
      .status_o (status_w)
   );

   spi_irq_mask #(.NUM_SRC(NUM_SRC)) u_mask (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_en (wr_mset),
      .clr_en (wr_mclr),
      .bits   (src_wdata),
      .mask_o (mask_w)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= 1'b0;
         wm_q   <= WM_W'(WM_RESET);
      end else begin
         if (wr_ctrl)  ctrl_q <= bus_wdata[0];
         if (wr_wmark) wm_q   <= bus_wdata[WM_W-1:0];
      end
   end

   always_comb begin
      rdata_c = '0;
      unique case (sel)
         SEL_STATUS: rdata_c[NUM_SRC-1:0] = status_w;
         SEL_MASK:   rdata_c[NUM_SRC-1:0] = mask_w;
         SEL_CTRL:   rdata_c[0]           = ctrl_q;
         SEL_WMARK:  rdata_c[WM_W-1:0]    = wm_q;
         default:    rdata_c              = '0;
      endcase
   end

   assign bus_rdata  = rdata_c;
   assign irq_o      = |(status_w & mask_w);
   assign ctrl_en_o  = ctrl_q;
   assign tx_wmark_o = wm_q;

endmodule

// File: rtl/spi_irq_regfile_chk.sv
module spi_irq_regfile_chk
   import spi_irq_pkg::*;
#(
   parameter int                 ADDR_W    = 6,
   parameter int                 NUM_SRC   = 7,
   parameter logic [NUM_SRC-1:0] LIVE_MASK = '0
) (
   input logic               clk,
   input logic               rst_n,
   input logic               bus_wr,
   input logic [ADDR_W-1:0]  bus_addr,
   input logic [NUM_SRC-1:0] wd,
   input logic [NUM_SRC-1:0] evt_i,
   input logic [NUM_SRC-1:0] status,
   input logic [NUM_SRC-1:0] mask,
   input logic               irq_o
);

   localparam logic [NUM_SRC-1:0] LATCHED = ~LIVE_MASK;

   AST_EVENT_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
      ((evt_i & LATCHED) != '0) |=> ((status & $past(evt_i & LATCHED)) == $past(evt_i & LATCHED))); // R5

   AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == ADDR_W'(OFS_STATUS)) |=> ((status & $past(wd & LATCHED & ~evt_i)) == '0)); // R3

   AST_MASK_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == ADDR_W'(OFS_MSET)) |=> ((mask & $past(wd)) == $past(wd))); // R6

   AST_MASK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == ADDR_W'(OFS_MCLR)) |=> ((mask & $past(wd)) == '0)); // R7

   AST_MASK_READ_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == ADDR_W'(OFS_MASK)) |=> $stable(mask)); // R8

   AST_NO_IRQ_ALL_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
      (mask == '0) |-> !irq_o); // R10

endmodule

bind spi_irq_regfile spi_irq_regfile_chk #(
   .ADDR_W    (ADDR_W),
   .NUM_SRC   (NUM_SRC),
   .LIVE_MASK (LIVE_MASK[NUM_SRC-1:0])
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .bus_wr   (bus_wr),
   .bus_addr (bus_addr),
   .wd       (bus_wdata[NUM_SRC-1:0]),
   .evt_i    (evt_i),
   .status   (status_w),
   .mask     (mask_w),
   .irq_o    (irq_o)
);

// File: tb/spi_irq_regfile_tb.sv
`timescale 1ns/1ps
module spi_irq_regfile_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [5:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [6:0]  evt_i = '0;
   logic        irq_o;
   logic        ctrl_en_o;
   logic [6:0]  tx_wmark_o;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 0;
   logic [6:0] lvl = '0;

   // behavioural reference state
   int m_lat, m_mask, m_ctrl, m_wm;
   localparam int LIVE = 'h18;

   always #4 clk = ~clk;

   spi_irq_regfile u_dut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_i(evt_i),
      .irq_o(irq_o), .ctrl_en_o(ctrl_en_o), .tx_wmark_o(tx_wmark_o)
   );

   function automatic int m_status();
      return (m_lat & ~LIVE & 'h7F) | (int'(evt_i) & LIVE);
   endfunction

   function automatic int m_read(int a);
      case (a)
         'h04: return m_status();
         'h10: return m_mask;
         'h14: return m_ctrl;
         'h28: return m_wm;
         default: return 0;
      endcase
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_lat = 0; m_mask = 0; m_ctrl = 0; m_wm = 1;
      end else begin
         if (bus_wr) begin
            case (int'(bus_addr))
               'h04: m_lat  = m_lat & ~int'(bus_wdata);
               'h08: m_mask = m_mask | (int'(bus_wdata) & 'h7F);
               'h0C: m_mask = m_mask & ~int'(bus_wdata);
               'h14: m_ctrl = int'(bus_wdata) & 1;
               'h28: m_wm   = int'(bus_wdata) & 'h7F;
               default: ;
            endcase
         end
         m_lat = (m_lat | int'(evt_i)) & ~LIVE & 'h7F;
      end
   end

   task automatic check(string req, int act, int exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   function automatic string tag_of(int a);
      case (a)
         'h04: return "R2 status";
         'h10: return "R6 mask";
         'h14: return "R11 ctrl";
         'h28: return "R12 wmark";
         default: return "R9 zero read";
      endcase
   endfunction

   // compare against the model on every falling edge
   always @(negedge clk) begin
      if (rst_n && !done) begin
         check(tag_of(int'(bus_addr)), int'(bus_rdata), m_read(int'(bus_addr)));
         check("R10 irq", int'(irq_o), ((m_status() & m_mask) != 0) ? 1 : 0);
         check("R11 ctrl_en_o", int'(ctrl_en_o), m_ctrl);
         check("R12 tx_wmark_o", int'(tx_wmark_o), m_wm);
      end
   end

   task automatic wr(int a, int d);
      @(posedge clk); #1;
      bus_wr = 1'b1; bus_addr = 6'(a); bus_wdata = 32'(d);
      @(posedge clk); #1;
      bus_wr = 1'b0;
   endtask

   task automatic wr_evt(int a, int d, logic [6:0] e);
      @(posedge clk); #1;
      bus_wr = 1'b1; bus_addr = 6'(a); bus_wdata = 32'(d); evt_i = lvl | e;
      @(posedge clk); #1;
      bus_wr = 1'b0; evt_i = lvl;
   endtask

   task automatic pulse(logic [6:0] e);
      @(posedge clk); #1; evt_i = lvl | e;
      @(posedge clk); #1; evt_i = lvl;
   endtask

   task automatic set_lvl(logic [6:0] v);
      @(posedge clk); #1; lvl = v; evt_i = v;
   endtask

   task automatic rd(int a, int exp, string req);
      bus_addr = 6'(a);
      @(negedge clk);
      check(req, int'(bus_rdata), exp);
   endtask

   task automatic irq_chk(int exp, string req);
      @(negedge clk);
      check(req, int'(irq_o), exp);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      // R1 reset state
      rd('h04, 'h00, "R1 status");
      rd('h10, 'h00, "R1 mask");
      rd('h14, 'h00, "R1 ctrl");
      rd('h28, 'h01, "R1 wmark");
      irq_chk(0, "R1 irq");
      // R2 latching
      pulse(7'h02);
      rd('h04, 'h02, "R2 mode fault latched");
      repeat (3) @(posedge clk);
      rd('h04, 'h02, "R2 held");
      irq_chk(0, "R10 masked");
      // R6 mask set
      wr('h08, 'h02);
      rd('h10, 'h02, "R6 enable");
      irq_chk(1, "R10 unmasked");
      wr('h08, 'h00);
      rd('h10, 'h02, "R6 zeros ignored");
      // R3 write-1-to-clear
      pulse(7'h25);
      rd('h04, 'h27, "R2 multi");
      wr('h04, 'h05);
      rd('h04, 'h22, "R3 w1c exact");
      // R4 live bits
      set_lvl(7'h10);
      rd('h04, 'h32, "R4 live rx");
      wr('h04, 'h10);
      rd('h04, 'h32, "R4 w1c no effect");
      set_lvl(7'h00);
      rd('h04, 'h22, "R4 live drop");
      // R5 set wins
      wr_evt('h04, 'h20, 7'h20);
      rd('h04, 'h22, "R5 set wins");
      // R7 mask clear
      wr('h0C, 'h02);
      rd('h10, 'h00, "R7 disable");
      irq_chk(0, "R10 after disable");
      wr('h08, 'hFFFF);
      rd('h10, 'h7F, "R6 upper bits dropped");
      wr('h0C, 'h00);
      rd('h10, 'h7F, "R7 zeros ignored");
      wr('h0C, 'h41);
      rd('h10, 'h3E, "R7 partial");
      // R8 mask read only
      wr('h10, 'h00);
      rd('h10, 'h3E, "R8 write ignored");
      // R9 zero reads
      rd('h08, 0, "R9 enable reads 0");
      rd('h0C, 0, "R9 disable reads 0");
      rd('h30, 0, "R9 unmapped");
      // R11 ctrl
      wr('h14, 'hFFFFFFFF);
      rd('h14, 1, "R11 ctrl set");
      check("R11 ctrl_en_o", int'(ctrl_en_o), 1);
      wr('h14, 0);
      rd('h14, 0, "R11 ctrl clear");
      // R12 watermark
      wr('h28, 'h55);
      rd('h28, 'h55, "R12 wmark");
      wr('h28, 'hFFFF);
      rd('h28, 'h7F, "R12 truncated");
      check("R12 tx_wmark_o", int'(tx_wmark_o), 'h7F);
      // R10 irq tracks clear and live source
      irq_chk(1, "R10 pending");
      wr('h04, 'h22);
      rd('h04, 'h00, "R3 cleared all");
      irq_chk(0, "R10 dropped");
      set_lvl(7'h08);
      irq_chk(1, "R10 live tx full");
      set_lvl(7'h00);
      irq_chk(0, "R10 live gone");
      repeat (2) @(posedge clk);
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      #100000;
      if (!done) begin
         done = 1;
         n_fail++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule